// File: doc/BRIEF.md
# Full/Empty Tagged Synchronization Memory

The block is a small word-addressed store in which each word carries one tag bit that says whether the word currently holds a value a consumer may take (full) or not (empty). Hardware threads send requests that carry their thread ID, an operation and an address. Plain accesses ignore the tag. A group of synchronizing operations uses the tag to order producers and consumers. A producer reserves a word, which marks it empty, and later fills it, which writes the value and marks it full. A consumer can take the word, which reads it and marks it empty so that other consumers wait. A consumer can also wait-read it, which reads it and leaves it full.

A synchronizing read that meets an empty word does not return data. The request is parked in a pending table that has one slot per thread, and it is retried every cycle. When several parked requests can proceed, the oldest one is served. The store has a single port, so one operation executes per cycle. Parked requests that can proceed take that port ahead of a new request, and a displaced new request is parked in turn. Each executed operation gives exactly one completion, tagged with the requesting thread, in the cycle after it executes.

Top module: `tagged_sync_mem`

## Requirements
- R1: After reset every tag is full, every data word is 0, `busy_o` is all zero and `cmpl_valid_o` is 0. A wait-read of any word therefore completes at once with data 0.
- R2: Plain read (op 0) returns the stored word whatever the tag, leaves the tag unchanged and completes in the cycle after it is presented when the store port is free.
- R3: Plain write (op 1) stores `req_wdata_i`, leaves the tag unchanged, and completes in the next cycle with data 0. A plain write to an empty word does not release waiting consumers.
- R4: Reserve (op 2) marks the word empty without changing its data, and completes in the next cycle with data 0.
- R5: Fill (op 3) stores `req_wdata_i`, marks the word full and completes with data 0. Whether the word was full or empty does not matter.
- R6: Take (op 4) on a full word returns its data and marks it empty.
- R7: Wait-read (op 5) on a full word returns its data and leaves it full.
- R8: A take or wait-read that meets an empty word gives no completion. It parks, and `busy_o[tid]` goes high in the next cycle. The first cycle after a fill to that word, it executes, and it completes in the cycle after that with the filled value.
- R9: Among parked requests that can proceed in the same cycle, the one parked earliest executes first, whatever the thread IDs. A take that empties the word leaves the younger waiters parked.
- R10: A parked request that can proceed has priority over a new request. The new request is then parked and completes one cycle after the retry.
- R11: A request from a thread whose slot is busy, and a request with an opcode of 6 or 7, are ignored. Neither gives a completion, and neither changes data, tags or `busy_o`.
- R12: At most one completion per cycle. `cmpl_tid_o` names the requesting thread, and that thread's `busy_o` bit is low while its completion is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is present this cycle |
| req_tid_i | input | TID_W | Requesting thread |
| req_op_i | input | 3 | Operation code (0 read, 1 write, 2 reserve, 3 fill, 4 take, 5 wait-read) |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data for write and fill |
| busy_o | output | NUM_THREADS | Thread has a parked request |
| cmpl_valid_o | output | 1 | Completion this cycle |
| cmpl_tid_o | output | TID_W | Thread that owns the completion |
| cmpl_rdata_o | output | DATA_W | Read data (0 for ops that return none) |

## Verification
A fill releases a parked consumer, and in the very next cycle that retry executes. The bench presents a plain read from another thread in exactly that cycle, so the retry and the new request contend for the single store port. The retry has to win and complete first with the filled value. The new request has to show up as busy and then complete one cycle later with its own data. A second case puts three waiters with mixed thread IDs on one word: age order decides who is served, and the take in the middle has to leave the youngest waiter parked until a second fill.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_WRITE   = 3'd1,
    OP_RESERVE = 3'd2,
    OP_FILL    = 3'd3,
    OP_TAKE    = 3'd4,
    OP_WAIT    = 3'd5
  } op_e;

  function automatic logic op_legal(logic [2:0] op);
    return op <= 3'd5;
  endfunction

  // op may only execute while its word is full
  function automatic logic needs_full(op_e op);
    return (op == OP_TAKE) || (op == OP_WAIT);
  endfunction

  function automatic logic returns_data(op_e op);
    return (op == OP_READ) || (op == OP_TAKE) || (op == OP_WAIT);
  endfunction

endpackage

// File: rtl/fe_tag_store.sv
module fe_tag_store #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exec_valid_i,
  input  fe_pkg::op_e       exec_op_i,
  input  logic [ADDR_W-1:0] exec_addr_i,
  input  logic [DATA_W-1:0] exec_wdata_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DEPTH-1:0]  tags_o
);
  import fe_pkg::*;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;
  logic [DEPTH-1:0]             tag_q;

  assign rd_data_o = mem_q[exec_addr_i];
  assign tags_o    = tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      tag_q <= '1;
    end else if (exec_valid_i) begin
      unique case (exec_op_i)
        OP_WRITE:   mem_q[exec_addr_i] <= exec_wdata_i;
        OP_RESERVE: tag_q[exec_addr_i] <= 1'b0;
        OP_FILL: begin
          mem_q[exec_addr_i] <= exec_wdata_i;
          tag_q[exec_addr_i] <= 1'b1;
        end
        OP_TAKE:    tag_q[exec_addr_i] <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fe_pending_table.sv
module fe_pending_table #(
  parameter int NUM_THREADS = 4,
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  localparam int TID_W      = $clog2(NUM_THREADS)
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  alloc_i,
  input  logic [TID_W-1:0]                      alloc_tid_i,
  input  fe_pkg::op_e                           alloc_op_i,
  input  logic [ADDR_W-1:0]                     alloc_addr_i,
  input  logic [DATA_W-1:0]                     alloc_wdata_i,
  input  logic                                  clr_i,
  input  logic [TID_W-1:0]                      clr_tid_i,
  output logic [NUM_THREADS-1:0]                vld_o,
  output fe_pkg::op_e [NUM_THREADS-1:0]         op_o,
  output logic [NUM_THREADS-1:0][ADDR_W-1:0]    addr_o,
  output logic [NUM_THREADS-1:0][DATA_W-1:0]    wdata_o,
  output logic [NUM_THREADS-1:0][NUM_THREADS-1:0] older_o
);
  import fe_pkg::*;

  logic [NUM_THREADS-1:0]                   vld_q;
  op_e  [NUM_THREADS-1:0]                   op_q;
  logic [NUM_THREADS-1:0][ADDR_W-1:0]       addr_q;
  logic [NUM_THREADS-1:0][DATA_W-1:0]       wdata_q;
  // older_q[i][j]: slot i was parked before slot j
  logic [NUM_THREADS-1:0][NUM_THREADS-1:0]  older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      op_q    <= {NUM_THREADS{OP_READ}};
      addr_q  <= '0;
      wdata_q <= '0;
      older_q <= '0;
    end else begin
      if (clr_i) vld_q[clr_tid_i] <= 1'b0;
      if (alloc_i) begin
        vld_q[alloc_tid_i]   <= 1'b1;
        op_q[alloc_tid_i]    <= alloc_op_i;
        addr_q[alloc_tid_i]  <= alloc_addr_i;
        wdata_q[alloc_tid_i] <= alloc_wdata_i;
        for (int j = 0; j < NUM_THREADS; j++) begin
          older_q[j][alloc_tid_i] <= vld_q[j] && (TID_W'(j) != alloc_tid_i);
          older_q[alloc_tid_i][j] <= 1'b0;
        end
      end
    end
  end

  assign vld_o   = vld_q;
  assign op_o    = op_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign older_o = older_q;

endmodule

// File: rtl/fe_oldest_pick.sv
module fe_oldest_pick #(
  parameter int NUM_THREADS = 4,
  localparam int TID_W      = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0]                  elig_i,
  input  logic [NUM_THREADS-1:0][NUM_THREADS-1:0] older_i,
  output logic                                    any_o,
  output logic [TID_W-1:0]                        idx_o
);

  logic [NUM_THREADS-1:0] grant;

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_slot
    logic [NUM_THREADS-1:0] ahead;
    always_comb begin
      for (int j = 0; j < NUM_THREADS; j++) ahead[j] = older_i[j][i] & elig_i[j];
    end
    assign grant[i] = elig_i[i] & ~|ahead;
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (grant[i]) idx_o = TID_W'(i);
    end
  end

  assign any_o = |grant;

endmodule

// File: rtl/tagged_sync_mem.sv
module tagged_sync_mem #(
  parameter int NUM_THREADS = 4,
  parameter int DEPTH       = 8,
  parameter int DATA_W      = 16,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [TID_W-1:0]       req_tid_i,
  input  logic [2:0]             req_op_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  output logic [NUM_THREADS-1:0] busy_o,
  output logic                   cmpl_valid_o,
  output logic [TID_W-1:0]       cmpl_tid_o,
  output logic [DATA_W-1:0]      cmpl_rdata_o
);
  import fe_pkg::*;

  logic [NUM_THREADS-1:0]                   slot_vld;
  op_e  [NUM_THREADS-1:0]                   slot_op;
  logic [NUM_THREADS-1:0][ADDR_W-1:0]       slot_addr;
  logic [NUM_THREADS-1:0][DATA_W-1:0]       slot_wdata;
  logic [NUM_THREADS-1:0][NUM_THREADS-1:0]  slot_older;
  logic [NUM_THREADS-1:0]                   slot_elig;

  logic [DEPTH-1:0]  tags;
  logic [DATA_W-1:0] rd_data;

  logic              grant_any;
  logic [TID_W-1:0]  grant_idx;

  op_e               req_op;
  logic              req_ok;
  logic              req_can_run;

  logic              exec_valid;
  logic [TID_W-1:0]  exec_tid;
  op_e               exec_op;
  logic [ADDR_W-1:0] exec_addr;
  logic [DATA_W-1:0] exec_wdata;
  logic              park;

  assign req_op      = op_e'(req_op_i);
  assign req_ok      = req_valid_i && op_legal(req_op_i) && !slot_vld[req_tid_i];
  assign req_can_run = !needs_full(req_op) || tags[req_addr_i];

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_elig
    assign slot_elig[i] = slot_vld[i] && (!needs_full(slot_op[i]) || tags[slot_addr[i]]);
  end

  // single store port: eligible retries first, then the new request
  always_comb begin
    exec_valid = 1'b0;
    exec_tid   = req_tid_i;
    exec_op    = req_op;
    exec_addr  = req_addr_i;
    exec_wdata = req_wdata_i;
    if (grant_any) begin
      exec_valid = 1'b1;
      exec_tid   = grant_idx;
      exec_op    = slot_op[grant_idx];
      exec_addr  = slot_addr[grant_idx];
      exec_wdata = slot_wdata[grant_idx];
    end else if (req_ok && req_can_run) begin
      exec_valid = 1'b1;
    end
  end

  assign park = req_ok && (grant_any || !req_can_run);

  fe_pending_table #(
    .NUM_THREADS(NUM_THREADS),
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W)
  ) i_pending (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .alloc_i      (park),
    .alloc_tid_i  (req_tid_i),
    .alloc_op_i   (req_op),
    .alloc_addr_i (req_addr_i),
    .alloc_wdata_i(req_wdata_i),
    .clr_i        (grant_any),
    .clr_tid_i    (grant_idx),
    .vld_o        (slot_vld),
    .op_o         (slot_op),
    .addr_o       (slot_addr),
    .wdata_o      (slot_wdata),
    .older_o      (slot_older)
  );

  fe_oldest_pick #(
    .NUM_THREADS(NUM_THREADS)
  ) i_pick (
    .elig_i (slot_elig),
    .older_i(slot_older),
    .any_o  (grant_any),
    .idx_o  (grant_idx)
  );

  fe_tag_store #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W)
  ) i_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exec_valid_i(exec_valid),
    .exec_op_i   (exec_op),
    .exec_addr_i (exec_addr),
    .exec_wdata_i(exec_wdata),
    .rd_data_o   (rd_data),
    .tags_o      (tags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmpl_valid_o <= 1'b0;
      cmpl_tid_o   <= '0;
      cmpl_rdata_o <= '0;
    end else begin
      cmpl_valid_o <= exec_valid;
      cmpl_tid_o   <= exec_tid;
      cmpl_rdata_o <= (exec_valid && returns_data(exec_op)) ? rd_data : '0;
    end
  end

  assign busy_o = slot_vld;

endmodule

// File: rtl/fe_sync_chk.sv
module fe_sync_chk #(
  parameter int NUM_THREADS = 4,
  parameter int DEPTH       = 8,
  localparam int TID_W      = $clog2(NUM_THREADS),
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   req_valid_i,
  input logic [TID_W-1:0]       req_tid_i,
  input logic [2:0]             req_op_i,
  input logic [NUM_THREADS-1:0] busy_o,
  input logic                   cmpl_valid_o,
  input logic [TID_W-1:0]       cmpl_tid_o,
  input logic                   exec_valid,
  input fe_pkg::op_e            exec_op,
  input logic [ADDR_W-1:0]      exec_addr,
  input logic [DEPTH-1:0]       tags
);
  import fe_pkg::*;

  // R2
  read_keeps_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid && exec_op == OP_READ |=> tags[$past(exec_addr)] == $past(tags[exec_addr]));

  // R3
  write_keeps_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid && exec_op == OP_WRITE |=> tags[$past(exec_addr)] == $past(tags[exec_addr]));

  // R4
  reserve_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid && exec_op == OP_RESERVE |=> !tags[$past(exec_addr)]);

  // R5
  fill_sets_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid && exec_op == OP_FILL |=> tags[$past(exec_addr)]);

  // R6
  take_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid && exec_op == OP_TAKE |=> !tags[$past(exec_addr)]);

  // R7
  wait_keeps_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid && exec_op == OP_WAIT |=> tags[$past(exec_addr)]);

  // R8
  blocked_needs_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid && (exec_op == OP_TAKE || exec_op == OP_WAIT) |-> tags[exec_addr]);

  // R10
  accepted_goes_somewhere_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && op_legal(req_op_i) && !busy_o[req_tid_i]
    |=> (cmpl_valid_o && cmpl_tid_o == $past(req_tid_i)) || busy_o[$past(req_tid_i)]);

  // R11
  illegal_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !op_legal(req_op_i) && !busy_o[req_tid_i]
    |=> !busy_o[$past(req_tid_i)] && !(cmpl_valid_o && cmpl_tid_o == $past(req_tid_i)));

  // R12
  cmpl_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_valid_o |-> !busy_o[cmpl_tid_o]);

endmodule

bind tagged_sync_mem fe_sync_chk #(
  .NUM_THREADS(NUM_THREADS),
  .DEPTH      (DEPTH)
) i_fe_sync_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_tid_i   (req_tid_i),
  .req_op_i    (req_op_i),
  .busy_o      (busy_o),
  .cmpl_valid_o(cmpl_valid_o),
  .cmpl_tid_o  (cmpl_tid_o),
  .exec_valid  (exec_valid),
  .exec_op     (exec_op),
  .exec_addr   (exec_addr),
  .tags        (tags)
);

// File: tb/test_tagged_sync_mem.sv
module test_tagged_sync_mem;
  localparam int NT = 4;
  localparam int DEPTH = 8;
  localparam int DW = 16;
  localparam logic [2:0] RD = 3'd0, WR = 3'd1, RSV = 3'd2, FIL = 3'd3, TAK = 3'd4, WTR = 3'd5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [1:0]    req_tid = '0;
  logic [2:0]    req_op = '0;
  logic [2:0]    req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NT-1:0] busy;
  logic          cmpl_valid;
  logic [1:0]    cmpl_tid;
  logic [DW-1:0] cmpl_rdata;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] mem_exp [DEPTH];

  always #2 clk = ~clk;

  tagged_sync_mem #(.NUM_THREADS(NT), .DEPTH(DEPTH), .DATA_W(DW)) i_tagged_sync_mem (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_tid_i(req_tid),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .busy_o(busy), .cmpl_valid_o(cmpl_valid), .cmpl_tid_o(cmpl_tid), .cmpl_rdata_o(cmpl_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // present one request for one edge; returns at the following negedge
  task automatic send(input logic [1:0] t, input logic [2:0] op, input logic [2:0] a,
                      input logic [DW-1:0] d);
    req_valid = 1'b1; req_tid = t; req_op = op; req_addr = a; req_wdata = d;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic exp_cmpl(input string req, input logic [1:0] t, input logic [DW-1:0] d);
    check({req, " valid"}, cmpl_valid, 1);
    check({req, " tid"}, cmpl_tid, t);
    check({req, " data"}, cmpl_rdata, d);
  endtask

  task automatic exp_none(input string req);
    check({req, " no completion"}, cmpl_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 cmpl", cmpl_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) begin
      send(2'(a % NT), WTR, 3'(a), '0);
      exp_cmpl("R1 full at reset", 2'(a % NT), '0);
      mem_exp[a] = '0;
    end

    // R2 R3 sweep: all threads x all addresses
    for (int t = 0; t < NT; t++) begin
      for (int a = 0; a < DEPTH; a++) begin
        v = DW'(a * 41 + t * 7 + 3);
        send(2'(t), WR, 3'(a), v);
        exp_cmpl("R3 write", 2'(t), '0);
        mem_exp[a] = v;
        send(2'((t + 1) % NT), RD, 3'(a), '0);
        exp_cmpl("R2 read", 2'((t + 1) % NT), v);
      end
    end

    // per-address producer/consumer sweep
    for (int a = 0; a < DEPTH; a++) begin
      send(0, RSV, 3'(a), 16'hFFFF);
      exp_cmpl("R4 reserve", 0, '0);
      send(1, WTR, 3'(a), '0);
      exp_none("R8 park");
      check("R8 busy", busy, 4'b0010);
      send(2, RD, 3'(a), '0);
      exp_cmpl("R2 read ignores empty tag, R4 data kept", 2, mem_exp[a]);
      v = DW'(16'h1000 + a * 3);
      send(3, FIL, 3'(a), v);
      exp_cmpl("R5 fill", 3, '0);
      mem_exp[a] = v;
      idle();
      exp_cmpl("R8 release", 1, v);
      check("R8 busy clear", busy, 0);
      send(0, TAK, 3'(a), '0);
      exp_cmpl("R6 take", 0, v);
      send(2, WTR, 3'(a), '0);
      exp_none("R6 take empties");
      v = DW'(16'h2000 + a * 5);
      send(3, FIL, 3'(a), v);
      exp_cmpl("R5 refill", 3, '0);
      mem_exp[a] = v;
      idle();
      exp_cmpl("R8 second release", 2, v);
      send(1, WTR, 3'(a), '0);
      exp_cmpl("R7 wait keeps full", 1, v);
      send(1, WTR, 3'(a), '0);
      exp_cmpl("R7 still full", 1, v);
      // plain write does not release
      send(0, RSV, 3'(a), '0);
      exp_cmpl("R4 reserve again", 0, '0);
      send(1, WR, 3'(a), 16'h0BAD);
      exp_cmpl("R3 write on empty", 1, '0);
      mem_exp[a] = 16'h0BAD;
      send(2, WTR, 3'(a), '0);
      exp_none("R3 write leaves empty");
      idle();
      exp_none("R3 still blocked");
      check("R3 busy", busy, 4'b0100);
      send(3, FIL, 3'(a), 16'h0C00 + 16'(a));
      exp_cmpl("R5 fill releases", 3, '0);
      mem_exp[a] = 16'h0C00 + 16'(a);
      idle();
      exp_cmpl("R5 waiter gets fill", 2, mem_exp[a]);
    end

    // R9 age order at addr 2
    send(3, RSV, 2, '0);
    exp_cmpl("R9 reserve", 3, '0);
    send(2, WTR, 2, '0);
    send(0, TAK, 2, '0);
    send(1, WTR, 2, '0);
    exp_none("R9 park three");
    check("R9 busy", busy, 4'b0111);
    send(3, FIL, 2, 16'hA5A5);
    exp_cmpl("R9 fill", 3, '0);
    idle();
    exp_cmpl("R9 oldest first", 2, 16'hA5A5);
    idle();
    exp_cmpl("R9 second oldest take", 0, 16'hA5A5);
    idle();
    exp_none("R9 youngest blocked after take");
    check("R9 busy youngest", busy, 4'b0010);
    send(3, FIL, 2, 16'h5A5A);
    exp_cmpl("R9 fill again", 3, '0);
    idle();
    exp_cmpl("R9 youngest released", 1, 16'h5A5A);
    mem_exp[2] = 16'h5A5A;

    // R10 retry beats new request
    send(1, RSV, 3, '0);
    send(0, TAK, 3, '0);
    exp_none("R10 park take");
    send(1, FIL, 3, 16'h1234);
    exp_cmpl("R10 fill", 1, '0);
    mem_exp[3] = 16'h1234;
    send(2, RD, 4, '0);
    exp_cmpl("R10 retry wins", 0, 16'h1234);
    check("R10 new parked", busy, 4'b0100);
    idle();
    exp_cmpl("R10 new completes later", 2, mem_exp[4]);
    check("R10 busy clear", busy, 0);
    send(1, FIL, 3, 16'h1234);
    exp_cmpl("R10 refill", 1, '0);

    // R11 ignored requests
    send(0, RSV, 5, '0);
    send(1, WTR, 5, '0);
    check("R11 setup busy", busy, 4'b0010);
    send(1, WR, 6, 16'hBEEF);
    exp_none("R11 busy thread ignored");
    check("R11 busy kept", busy, 4'b0010);
    send(3, 3'd7, 6, 16'hBEEF);
    exp_none("R11 illegal op ignored");
    send(3, 3'd6, 6, 16'hBEEF);
    exp_none("R11 opcode 6 ignored");
    check("R11 busy unchanged", busy, 4'b0010);
    send(0, RD, 6, '0);
    exp_cmpl("R11 data unchanged", 0, mem_exp[6]);
    send(0, WTR, 6, '0);
    exp_cmpl("R11 tag unchanged", 0, mem_exp[6]);
    send(2, FIL, 5, 16'h7777);
    exp_cmpl("R12 fill tid", 2, '0);
    idle();
    exp_cmpl("R12 waiter tid", 1, 16'h7777);
    idle();
    exp_none("R12 single completion");
    check("R12 final busy", busy, 0);

    summary();
  end

endmodule